// File: doc/BRIEF.md
# Bus-to-Device Read/Write Handshake Controller

This clocked controller sits between a bus slave port and a local peripheral and turns each bus strobe into a fully interlocked exchange of level handshakes. The bus raises a read request or a write request and waits for the controller's bus acknowledge. The controller drives a device request toward the peripheral, collects the device acknowledge, and switches a data transceiver enable on and off. That enable places read data onto the bus, or takes write data off it.

Each cycle follows a fixed order of output changes, and the order depends on the cycle type. On a read, the transceiver opens only after the device has answered. On a write, the transceiver opens first and closes again before the bus is acknowledged. After either cycle the controller waits for the device acknowledge to return low. Only then can a new device request go out. A sticky error flag records any input that arrives out of its expected order. The controller ignores such an input and holds its state in that cycle. All inputs are assumed to be synchronized already.

Top module: `hs_ctrl`

## Requirements
- R1: Synchronous active-high reset clears `dev_req`, `xcvr_en`, `bus_ack` and `proto_err`. The controller then waits idle.
- R2: Read order, as vectors {dev_req,xcvr_en,bus_ack}. From idle, a read request moves the vector 000→100. Device acknowledge high moves it to 110, and one clock later to 111. Read request low moves it to 101, and one clock later to 000.
- R3: Write order, as vectors {dev_req,xcvr_en,bus_ack}. From idle, a write request moves the vector 000→010, and one clock later to 110. Device acknowledge high moves it to 100, and one clock later to 101. Write request low moves it to 000.
- R4: After a cycle ends, `dev_req` does not rise again until `dev_ack` has been sampled low.
- R5: While the input a state is waiting for is absent, the outputs hold. Each step appears on the outputs one clock after the edge that samples its input.
- R6: Both requests high together while idle set `proto_err`, and no cycle starts.
- R7: An input out of order sets `proto_err`, and the state does not advance in that cycle. This covers device acknowledge high while idle, a request dropped before the bus is acknowledged, device acknowledge low while the device request is held, and the other request rising during a cycle.
- R8: `proto_err` stays high until reset.
- R9: `bus_ack` rises only while `dev_ack` was high on the previous edge. It never rises in the same clock as a change of `dev_req` or `xcvr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd_req | input | 1 | Bus read request level |
| bus_wr_req | input | 1 | Bus write request level |
| bus_ack | output | 1 | Acknowledge to the bus |
| dev_req | output | 1 | Request to the device |
| dev_ack | input | 1 | Acknowledge from the device |
| xcvr_en | output | 1 | Data transceiver enable |
| proto_err | output | 1 | Sticky protocol violation flag |

## Verification
The assertions check four things on every cycle. A device request never rises over a high device acknowledge. The bus acknowledge rises only after the device acknowledge and never together with another output change. The error flag is sticky, and the outputs stay frozen in the cycle an error is raised. Only the bench scenarios can show the full order of both cycle types, how long each step takes, and that a new read waits for the device to release. They also show that each class of misordered input is caught. The bench drives a random mix of reads and writes with random device and bus delays, plus directed fault injections.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE   = 4'd0,
        ST_R_REQ  = 4'd1,
        ST_R_DATA = 4'd2,
        ST_R_ACK  = 4'd3,
        ST_R_REL  = 4'd4,
        ST_W_DATA = 4'd5,
        ST_W_REQ  = 4'd6,
        ST_W_DROP = 4'd7,
        ST_W_ACK  = 4'd8,
        ST_RTZ    = 4'd9
    } hs_state_e;

    typedef struct packed {
        logic dev_req;
        logic xcvr_en;
        logic bus_ack;
    } hs_out_t;

    typedef struct packed {
        logic rd;
        logic wr;
        logic dack;
    } hs_in_t;

    function automatic hs_out_t out_of(hs_state_e s);
        hs_out_t o;
        o = '0;
        case (s)
            ST_R_REQ:  o = '{dev_req: 1'b1, xcvr_en: 1'b0, bus_ack: 1'b0};
            ST_R_DATA: o = '{dev_req: 1'b1, xcvr_en: 1'b1, bus_ack: 1'b0};
            ST_R_ACK:  o = '{dev_req: 1'b1, xcvr_en: 1'b1, bus_ack: 1'b1};
            ST_R_REL:  o = '{dev_req: 1'b1, xcvr_en: 1'b0, bus_ack: 1'b1};
            ST_W_DATA: o = '{dev_req: 1'b0, xcvr_en: 1'b1, bus_ack: 1'b0};
            ST_W_REQ:  o = '{dev_req: 1'b1, xcvr_en: 1'b1, bus_ack: 1'b0};
            ST_W_DROP: o = '{dev_req: 1'b1, xcvr_en: 1'b0, bus_ack: 1'b0};
            ST_W_ACK:  o = '{dev_req: 1'b1, xcvr_en: 1'b0, bus_ack: 1'b1};
            default:   o = '0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/hs_viol.sv
module hs_viol
    import hs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  hs_state_e state,
    input  hs_in_t    in,
    output logic      viol,
    output logic      err_q
);

    always_comb begin
        viol = 1'b0;
        case (state)
            ST_IDLE:   viol = (in.rd & in.wr) | in.dack;
            ST_R_REQ:  viol = ~in.rd | in.wr;
            ST_R_DATA: viol = ~in.rd | in.wr | ~in.dack;
            ST_R_ACK:  viol = in.wr | ~in.dack;
            ST_R_REL:  viol = in.rd | in.wr | ~in.dack;
            ST_W_DATA: viol = ~in.wr | in.rd | in.dack;
            ST_W_REQ:  viol = ~in.wr | in.rd;
            ST_W_DROP: viol = ~in.wr | in.rd | ~in.dack;
            ST_W_ACK:  viol = in.rd | ~in.dack;
            default:   viol = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= err_q | viol;
    end

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

endmodule

// File: rtl/hs_seq.sv
module hs_seq
    import hs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  hs_in_t    in,
    input  logic      viol,
    output hs_state_e state,
    output hs_state_e nxt
);

    always_comb begin
        nxt = state;
        if (!viol) begin
            case (state)
                ST_IDLE:   if (in.rd) nxt = ST_R_REQ;
                           else if (in.wr) nxt = ST_W_DATA;
                ST_R_REQ:  if (in.dack) nxt = ST_R_DATA;
                ST_R_DATA: nxt = ST_R_ACK;
                ST_R_ACK:  if (!in.rd) nxt = ST_R_REL;
                ST_R_REL:  nxt = ST_RTZ;
                ST_W_DATA: nxt = ST_W_REQ;
                ST_W_REQ:  if (in.dack) nxt = ST_W_DROP;
                ST_W_DROP: nxt = ST_W_ACK;
                ST_W_ACK:  if (!in.wr) nxt = ST_RTZ;
                ST_RTZ:    if (!in.dack) nxt = ST_IDLE;
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

endmodule

// File: rtl/hs_outreg.sv
module hs_outreg
    import hs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  hs_state_e nxt,
    output hs_out_t   q
);

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= out_of(nxt);
    end

endmodule

// File: rtl/hs_ctrl.sv
module hs_ctrl
    import hs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bus_rd_req,
    input  logic bus_wr_req,
    output logic bus_ack,
    output logic dev_req,
    input  logic dev_ack,
    output logic xcvr_en,
    output logic proto_err
);

    hs_in_t    in_s;
    hs_state_e state, nxt;
    hs_out_t   outs;
    logic      viol;

    assign in_s = '{rd: bus_rd_req, wr: bus_wr_req, dack: dev_ack};

    hs_viol u_viol (
        .clk(clk), .rst(rst), .state(state), .in(in_s),
        .viol(viol), .err_q(proto_err)
    );

    hs_seq u_seq (
        .clk(clk), .rst(rst), .in(in_s), .viol(viol),
        .state(state), .nxt(nxt)
    );

    hs_outreg u_out (
        .clk(clk), .rst(rst), .nxt(nxt), .q(outs)
    );

    assign dev_req = outs.dev_req;
    assign xcvr_en = outs.xcvr_en;
    assign bus_ack = outs.bus_ack;

    assert_rtz_before_req_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(dev_req) |-> !$past(dev_ack));

    assert_ack_after_dev_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_ack) |-> $past(dev_ack));

    assert_ack_alone_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_ack) |-> ($stable(dev_req) && $stable(xcvr_en)));

    assert_err_freezes_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(proto_err) |-> $stable(outs));

    assert_idle_start_R3: assert property (@(posedge clk) disable iff (rst)
        ($rose(xcvr_en) && !dev_req) |-> ($past(bus_wr_req) && !$past(bus_rd_req)));

endmodule

// File: tb/test_hs_ctrl.sv
module test_hs_ctrl;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rd = 1'b0, wr = 1'b0, dack = 1'b0;
    logic bus_ack, dev_req, xcvr_en, proto_err;
    int   checks = 0;
    int   failures = 0;
    int   cycles = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    hs_ctrl i_hs_ctrl (
        .clk(clk), .rst(rst), .bus_rd_req(rd), .bus_wr_req(wr),
        .bus_ack(bus_ack), .dev_req(dev_req), .dev_ack(dack),
        .xcvr_en(xcvr_en), .proto_err(proto_err)
    );

    function automatic logic [2:0] outv();
        return {dev_req, xcvr_en, bus_ack};
    endfunction

    // expected {dev_req,xcvr_en,bus_ack} after step idx of a read or write
    function automatic logic [2:0] exp_vec(bit is_read, int idx);
        logic [2:0] rdv [5] = '{3'b100, 3'b110, 3'b111, 3'b101, 3'b000};
        logic [2:0] wrv [5] = '{3'b010, 3'b110, 3'b100, 3'b101, 3'b000};
        return is_read ? rdv[idx] : wrv[idx];
    endfunction

    task automatic check(bit ok, string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // wait for the output vector to change, then compare; n = cycles taken
    task automatic step(logic [2:0] exp, string req, int max_cyc);
        logic [2:0] prev = outv();
        int n = 0;
        while (n < 40) begin
            @(negedge clk);
            n++;
            if (outv() != prev) break;
        end
        check(outv() == exp && n <= max_cyc, req, {1'b0, outv()}, {1'b0, exp});
    endtask

    task automatic idle_wait(int d);
        repeat (d) @(negedge clk);
    endtask

    task automatic do_reset();
        rd = 0; wr = 0; dack = 0; rst = 1;
        idle_wait(2);
        rst = 0;
        @(negedge clk);
        check(outv() == 3'b000 && !proto_err, "R1", {proto_err, outv()}, 4'b0000);
    endtask

    task automatic txn(bit is_read, int d1, int d2, int d3);
        if (is_read) rd = 1; else wr = 1;
        step(exp_vec(is_read, 0), is_read ? "R2" : "R3", 1);
        if (!is_read) step(exp_vec(0, 1), "R3", 1);
        idle_wait(d1);
        check(outv() == (is_read ? 3'b100 : 3'b110), "R5", {1'b0, outv()},
              {1'b0, is_read ? 3'b100 : 3'b110});
        dack = 1;
        if (is_read) begin
            step(exp_vec(1, 1), "R2", 1);
            step(exp_vec(1, 2), "R2", 1);
        end else begin
            step(exp_vec(0, 2), "R3", 1);
            step(exp_vec(0, 3), "R3", 1);
        end
        idle_wait(d2);
        check(bus_ack == 1'b1, "R5", {3'b0, bus_ack}, 4'b0001);
        if (is_read) begin
            rd = 0;
            step(exp_vec(1, 3), "R2", 1);
            step(exp_vec(1, 4), "R2", 1);
        end else begin
            wr = 0;
            step(exp_vec(0, 4), "R3", 1);
        end
        idle_wait(d3);
        dack = 0;
        idle_wait(2);
        check(!proto_err, "R7", {3'b0, proto_err}, 4'b0000);
    endtask

    initial begin
        void'($urandom(32'd4242));
        do_reset();

        txn(1, 2, 1, 1);
        txn(0, 0, 3, 2);

        // R4: new read request while the device still holds its acknowledge
        rd = 1;
        step(3'b100, "R2", 1);
        dack = 1;
        step(3'b110, "R2", 1);
        step(3'b111, "R2", 1);
        rd = 0;
        step(3'b101, "R2", 1);
        step(3'b000, "R2", 1);
        rd = 1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(dev_req == 1'b0, "R4", {3'b0, dev_req}, 4'b0000);
        end
        dack = 0;
        step(3'b100, "R4", 3);
        dack = 1;
        step(3'b110, "R2", 1);
        step(3'b111, "R2", 1);
        rd = 0;
        step(3'b101, "R2", 1);
        step(3'b000, "R2", 1);
        dack = 0;
        idle_wait(2);

        // random mix of cycle types and delays
        for (int k = 0; k < 40; k++) begin
            txn(bit'($urandom % 2), $urandom_range(0, 4), $urandom_range(0, 4),
                $urandom_range(0, 4));
        end

        // R6: both requests together while idle
        rd = 1; wr = 1;
        idle_wait(2);
        check(proto_err && outv() == 3'b000, "R6", {proto_err, outv()}, 4'b1000);
        rd = 0; wr = 0;
        idle_wait(4);
        check(proto_err == 1'b1, "R8", {3'b0, proto_err}, 4'b0001);
        do_reset();

        // R7: device acknowledge while idle
        dack = 1;
        idle_wait(2);
        check(proto_err && outv() == 3'b000, "R7", {proto_err, outv()}, 4'b1000);
        do_reset();

        // R7: read request dropped before device answers; state frozen
        rd = 1;
        step(3'b100, "R2", 1);
        rd = 0;
        idle_wait(3);
        check(proto_err && outv() == 3'b100, "R7", {proto_err, outv()}, 4'b1100);
        do_reset();

        // R7: device acknowledge dropped while the bus is acknowledged (write)
        wr = 1;
        step(3'b010, "R3", 1);
        step(3'b110, "R3", 1);
        dack = 1;
        step(3'b100, "R3", 1);
        step(3'b101, "R3", 1);
        dack = 0;
        idle_wait(3);
        check(proto_err && outv() == 3'b101, "R7", {proto_err, outv()}, 4'b1101);
        do_reset();

        // R7: other request rising during a read
        rd = 1;
        step(3'b100, "R2", 1);
        wr = 1;
        idle_wait(2);
        check(proto_err && outv() == 3'b100, "R7", {proto_err, outv()}, 4'b1100);
        do_reset();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule